// File: doc/BRIEF.md
# Register-Window Pointer Controller

This block keeps the current window pointer of a processor whose 32-entry visible register set slides over a ring of `NWIN` physical windows. It accepts one command per cycle: descend into a fresh window, climb back to the caller's window, return from a trap, write the status word, or load the invalid-window mask. For each command it either commits the new machine state or raises a trap. When it traps, the window pointer keeps its value.

Moves go round the ring modulo `NWIN`. The window a move lands on is tested against a 32-bit invalid mask that software writes. Descending onto an invalid window raises an overflow trap, and climbing onto one raises an underflow trap. Return-from-trap is refused when traps are already enabled. Otherwise it enables traps, climbs one window and, if that climb succeeds, copies the saved supervisor bit back into the supervisor bit.

Commands arrive on a valid/ready port. `cmd_ready` is high in every cycle outside reset, so the block never applies back-pressure. A command transfers on any clock edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low, the source must hold the command. The status word is a plain combinational read of the committed state. A trap is reported as a registered one-cycle pulse together with a cause code.

Top module: `winptr_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the state is: pointer 0, supervisor 1, saved-supervisor 0, trap-enable 0, interrupt level 0, invalid mask all zero, and no trap pulse.
- R2: A descend command (op 1) targets `(cwp + NWIN - 1) mod NWIN`. If the mask bit of that target is clear, the target becomes the new pointer.
- R3: A descend command whose target has its mask bit set raises a trap with cause 2 (overflow). The pointer and all other state stay unchanged.
- R4: A climb command (op 2) targets `(cwp + 1) mod NWIN`. If the mask bit of that target is clear, the target becomes the new pointer.
- R5: A climb command whose target has its mask bit set raises a trap with cause 3 (underflow). The pointer stays unchanged.
- R6: A return-from-trap command (op 3) issued while trap-enable is 1 raises a trap with cause 1 (illegal) and changes nothing.
- R7: A return-from-trap command issued while trap-enable is 0 sets trap-enable to 1 and targets `(cwp + 1) mod NWIN`. If the target is valid, the pointer moves there and supervisor takes the value of saved-supervisor. If the target is invalid, the block raises cause 3, and the pointer and supervisor bit keep their values.
- R8: A status write (op 4) takes the pointer from bits 4:0, supervisor from bit 5, saved-supervisor from bit 6, trap-enable from bit 7 and interrupt level from bits 11:8. If the pointer field is `NWIN` or greater, the block raises cause 1 and changes nothing.
- R9: `stat_word_o` carries the pointer in bits 4:0, supervisor in bit 5, saved-supervisor in bit 6, trap-enable in bit 7 and interrupt level in bits 11:8. All other bits read 0.
- R10: A mask write (op 5) loads all 32 bits of `cmd_data`. Bit i set marks window i invalid. Bits at positions `NWIN` and above have no effect on any move.
- R11: `trap_req_o` is high for exactly the one cycle after a trapping command, and `trap_cause_o` is nonzero only in that cycle. An idle beat (`cmd_valid` low) and ops 0, 6 and 7 change no state and raise no trap.
- R12: `cmd_ready` is low during reset and high otherwise, so a command transfers in every cycle that `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Command code (0 idle, 1 descend, 2 climb, 3 return-from-trap, 4 status write, 5 mask write) |
| cmd_data | input | 32 | Status word or mask for the write commands |
| cwp_o | output | 5 | Committed window pointer |
| sup_o | output | 1 | Supervisor bit |
| prev_sup_o | output | 1 | Saved-supervisor bit |
| trap_en_o | output | 1 | Trap-enable bit |
| pil_o | output | 4 | Interrupt level field |
| stat_word_o | output | 32 | Packed status word for reads |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_cause_o | output | 3 | Trap cause (0 none, 1 illegal, 2 overflow, 3 underflow) |

## Verification
The bench runs seven copies of the block side by side, one for each ring size from 2 to 8. All seven receive the same command stream, so every wrap edge is hit at every size. A design that wrapped at the wrong size would land on pointer values of `NWIN` or above, or would skip window `NWIN-1`. A design that checked the mask bit of the current window instead of the target would trap on the wrong moves. The corner cases are these:
- Return-from-trap onto an invalid window must leave trap-enable set while the pointer stays put. A design that undid the whole command would leave trap-enable at 0.
- A status write that names a pointer exactly equal to `NWIN` must be refused. A design with an off-by-one limit would accept it.
- Random masks with bits set above `NWIN` show up any design that reads those bits.

// File: rtl/winptr_pkg.sv
package winptr_pkg;

  localparam int PTR_W = 5;
  localparam int PIL_W = 4;

  // status word field positions
  localparam int SB_SUP    = 5;
  localparam int SB_PSUP   = 6;
  localparam int SB_TEN    = 7;
  localparam int SB_PIL_LO = 8;
  localparam int SB_PIL_HI = SB_PIL_LO + PIL_W - 1;
  localparam int STAT_USED = SB_PIL_HI + 1;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_DESCEND = 3'd1,
    OP_CLIMB   = 3'd2,
    OP_TRETURN = 3'd3,
    OP_WSTAT   = 3'd4,
    OP_WMASK   = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } win_op_e;

  typedef enum logic [2:0] {
    TC_NONE      = 3'd0,
    TC_ILLEGAL   = 3'd1,
    TC_OVERFLOW  = 3'd2,
    TC_UNDERFLOW = 3'd3
  } trap_code_e;

  typedef struct packed {
    logic [PTR_W-1:0] cwp;
    logic             sup;
    logic             prev_sup;
    logic             trap_en;
    logic [PIL_W-1:0] pil;
  } win_state_t;

  localparam win_state_t WIN_STATE_RESET = '{
    cwp:      '0,
    sup:      1'b1,
    prev_sup: 1'b0,
    trap_en:  1'b0,
    pil:      '0
  };

endpackage

// File: rtl/winptr_neighbor.sv
// Computes the neighbouring window in one direction around the ring and
// looks up whether that window is marked invalid.
module winptr_neighbor
  import winptr_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter bit UPWARD = 1'b1
) (
  input  logic [PTR_W-1:0] cur_i,
  input  logic [31:0]      mask_i,
  output logic [PTR_W-1:0] tgt_o,
  output logic             bad_o
);

  localparam bit               FULL_RING = (NWIN == (1 << PTR_W));
  localparam logic [PTR_W-1:0] TOP_WIN   = PTR_W'(NWIN - 1);

  generate
    if (FULL_RING) begin : g_natural
      // ring size equals the field range: the adder wraps by itself
      if (UPWARD) begin : g_up
        assign tgt_o = cur_i + 1'b1;
      end else begin : g_dn
        assign tgt_o = cur_i - 1'b1;
      end
    end else begin : g_compare
      if (UPWARD) begin : g_up
        assign tgt_o = (cur_i == TOP_WIN) ? '0 : cur_i + 1'b1;
      end else begin : g_dn
        assign tgt_o = (cur_i == '0) ? TOP_WIN : cur_i - 1'b1;
      end
    end
  endgenerate

  // target is always below NWIN, so mask bits above the ring are never read
  assign bad_o = mask_i[tgt_o];

endmodule

// File: rtl/winptr_decide.sv
// Pure command decode: next state, mask write strobe and trap outcome.
module winptr_decide
  import winptr_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic                 accept_i,
  input  win_op_e              op_i,
  input  logic [STAT_USED-1:0] wdata_i,
  input  win_state_t           cur_i,
  input  logic [PTR_W-1:0]     up_tgt_i,
  input  logic                 up_bad_i,
  input  logic [PTR_W-1:0]     dn_tgt_i,
  input  logic                 dn_bad_i,
  output win_state_t           nxt_o,
  output logic                 mask_we_o,
  output logic                 trap_o,
  output trap_code_e           cause_o
);

  localparam logic [PTR_W:0] WIN_LIMIT = (PTR_W+1)'(NWIN);

  logic [PTR_W-1:0] wr_ptr;
  logic             wr_ptr_ok;

  assign wr_ptr    = wdata_i[PTR_W-1:0];
  assign wr_ptr_ok = {1'b0, wr_ptr} < WIN_LIMIT;

  always_comb begin
    nxt_o     = cur_i;
    mask_we_o = 1'b0;
    trap_o    = 1'b0;
    cause_o   = TC_NONE;
    if (accept_i) begin
      unique case (op_i)
        OP_DESCEND: begin
          if (dn_bad_i) begin
            trap_o  = 1'b1;
            cause_o = TC_OVERFLOW;
          end else begin
            nxt_o.cwp = dn_tgt_i;
          end
        end
        OP_CLIMB: begin
          if (up_bad_i) begin
            trap_o  = 1'b1;
            cause_o = TC_UNDERFLOW;
          end else begin
            nxt_o.cwp = up_tgt_i;
          end
        end
        OP_TRETURN: begin
          if (cur_i.trap_en) begin
            trap_o  = 1'b1;
            cause_o = TC_ILLEGAL;
          end else begin
            // trap-enable is committed even when the climb is refused
            nxt_o.trap_en = 1'b1;
            if (up_bad_i) begin
              trap_o  = 1'b1;
              cause_o = TC_UNDERFLOW;
            end else begin
              nxt_o.cwp = up_tgt_i;
              nxt_o.sup = cur_i.prev_sup;
            end
          end
        end
        OP_WSTAT: begin
          if (!wr_ptr_ok) begin
            trap_o  = 1'b1;
            cause_o = TC_ILLEGAL;
          end else begin
            nxt_o.cwp      = wr_ptr;
            nxt_o.sup      = wdata_i[SB_SUP];
            nxt_o.prev_sup = wdata_i[SB_PSUP];
            nxt_o.trap_en  = wdata_i[SB_TEN];
            nxt_o.pil      = wdata_i[SB_PIL_HI:SB_PIL_LO];
          end
        end
        OP_WMASK: mask_we_o = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/winptr_ctrl.sv
module winptr_ctrl
  import winptr_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [2:0]           cmd_op,
  input  logic [31:0]          cmd_data,
  output logic [PTR_W-1:0]     cwp_o,
  output logic                 sup_o,
  output logic                 prev_sup_o,
  output logic                 trap_en_o,
  output logic [PIL_W-1:0]     pil_o,
  output logic [31:0]          stat_word_o,
  output logic                 trap_req_o,
  output logic [2:0]           trap_cause_o
);

  win_state_t       state_q, state_d;
  logic [31:0]      mask_q;
  logic             trap_q, trap_d;
  trap_code_e       cause_q, cause_d;
  logic             mask_we;
  logic             accept;
  logic [PTR_W-1:0] up_tgt, dn_tgt;
  logic             up_bad, dn_bad;

  assign cmd_ready = rst_n;
  assign accept    = cmd_valid && cmd_ready;

  winptr_neighbor #(.NWIN(NWIN), .UPWARD(1'b1)) u_up (
    .cur_i  (state_q.cwp),
    .mask_i (mask_q),
    .tgt_o  (up_tgt),
    .bad_o  (up_bad)
  );

  winptr_neighbor #(.NWIN(NWIN), .UPWARD(1'b0)) u_dn (
    .cur_i  (state_q.cwp),
    .mask_i (mask_q),
    .tgt_o  (dn_tgt),
    .bad_o  (dn_bad)
  );

  winptr_decide #(.NWIN(NWIN)) u_decide (
    .accept_i  (accept),
    .op_i      (win_op_e'(cmd_op)),
    .wdata_i   (cmd_data[STAT_USED-1:0]),
    .cur_i     (state_q),
    .up_tgt_i  (up_tgt),
    .up_bad_i  (up_bad),
    .dn_tgt_i  (dn_tgt),
    .dn_bad_i  (dn_bad),
    .nxt_o     (state_d),
    .mask_we_o (mask_we),
    .trap_o    (trap_d),
    .cause_o   (cause_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WIN_STATE_RESET;
      mask_q  <= '0;
      trap_q  <= 1'b0;
      cause_q <= TC_NONE;
    end else begin
      state_q <= state_d;
      if (mask_we) mask_q <= cmd_data;
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  assign cwp_o        = state_q.cwp;
  assign sup_o        = state_q.sup;
  assign prev_sup_o   = state_q.prev_sup;
  assign trap_en_o    = state_q.trap_en;
  assign pil_o        = state_q.pil;
  assign trap_req_o   = trap_q;
  assign trap_cause_o = cause_q;

  always_comb begin
    stat_word_o                        = '0;
    stat_word_o[PTR_W-1:0]             = state_q.cwp;
    stat_word_o[SB_SUP]                = state_q.sup;
    stat_word_o[SB_PSUP]               = state_q.prev_sup;
    stat_word_o[SB_TEN]                = state_q.trap_en;
    stat_word_o[SB_PIL_HI:SB_PIL_LO]   = state_q.pil;
  end

endmodule

// File: rtl/winptr_ctrl_chk.sv
module winptr_ctrl_chk
  import winptr_pkg::*;
#(
  parameter int NWIN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [PTR_W-1:0] cwp_o,
  input logic             trap_en_o,
  input logic             trap_req_o,
  input logic [2:0]       trap_cause_o,
  input logic [31:0]      stat_word_o
);

  function automatic logic [PTR_W-1:0] ring_below(input logic [PTR_W-1:0] c);
    return (c == '0) ? PTR_W'(NWIN - 1) : c - 1'b1;
  endfunction

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_ptr_in_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cwp_o} < (PTR_W+1)'(NWIN)));

  p_descend_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_DESCEND) |=> (trap_req_o || cwp_o == ring_below($past(cwp_o))));

  p_trap_keeps_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == OP_DESCEND || cmd_op == OP_CLIMB || cmd_op == OP_WSTAT))
      |=> (!trap_req_o || $stable(cwp_o)));

  p_return_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_TRETURN && trap_en_o) |=> (trap_req_o && trap_cause_o == TC_ILLEGAL));

  p_return_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_TRETURN) |=> trap_en_o);

  p_status_pack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word_o[PTR_W-1:0] == cwp_o && stat_word_o[SB_TEN] == trap_en_o
     && stat_word_o[31:STAT_USED] == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !trap_req_o);

  p_cause_with_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o == (trap_cause_o != TC_NONE));

endmodule

bind winptr_ctrl winptr_ctrl_chk #(.NWIN(NWIN)) u_winptr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .cwp_o        (cwp_o),
  .trap_en_o    (trap_en_o),
  .trap_req_o   (trap_req_o),
  .trap_cause_o (trap_cause_o),
  .stat_word_o  (stat_word_o)
);

// File: tb/winptr_ctrl_bench.sv
module winptr_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NLO = 2;
  localparam int NHI = 8;
  localparam int RAND_STEPS = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_data = '0;

  logic        o_rdy   [NLO:NHI];
  logic [4:0]  o_cwp   [NLO:NHI];
  logic        o_s     [NLO:NHI];
  logic        o_ps    [NLO:NHI];
  logic        o_et    [NLO:NHI];
  logic [3:0]  o_pil   [NLO:NHI];
  logic [31:0] o_stat  [NLO:NHI];
  logic        o_trap  [NLO:NHI];
  logic [2:0]  o_cause [NLO:NHI];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar gi = NLO; gi <= NHI; gi++) begin : g_ring
    winptr_ctrl #(.NWIN(gi)) u_winptr_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (o_rdy[gi]),
      .cmd_op       (cmd_op),
      .cmd_data     (cmd_data),
      .cwp_o        (o_cwp[gi]),
      .sup_o        (o_s[gi]),
      .prev_sup_o   (o_ps[gi]),
      .trap_en_o    (o_et[gi]),
      .pil_o        (o_pil[gi]),
      .stat_word_o  (o_stat[gi]),
      .trap_req_o   (o_trap[gi]),
      .trap_cause_o (o_cause[gi])
    );
  end

  // reference model
  int          m_cwp  [NLO:NHI];
  int          m_s    [NLO:NHI];
  int          m_ps   [NLO:NHI];
  int          m_et   [NLO:NHI];
  int          m_pil  [NLO:NHI];
  int          e_trap [NLO:NHI];
  int          e_cause[NLO:NHI];
  string       e_tag  [NLO:NHI];
  logic [31:0] m_mask;

  int  vec_cnt  = 0;
  int  miss_cnt = 0;
  bit  done     = 1'b0;
  logic [31:0] rng = 32'h1d872b41;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      miss_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = NLO; n <= NHI; n++) begin
      m_cwp[n] = 0; m_s[n] = 1; m_ps[n] = 0; m_et[n] = 0; m_pil[n] = 0;
      e_trap[n] = 0; e_cause[n] = 0; e_tag[n] = "R1";
    end
    m_mask = '0;
  endtask

  task automatic verify();
    for (int n = NLO; n <= NHI; n++) begin
      int st;
      st = m_cwp[n] | (m_s[n] << 5) | (m_ps[n] << 6) | (m_et[n] << 7) | (m_pil[n] << 8);
      chk(o_rdy[n] == 1'b1, "R12", $sformatf("ready n=%0d", n), int'(o_rdy[n]), 1);
      chk(int'(o_trap[n]) == e_trap[n], e_tag[n], $sformatf("trap_req n=%0d", n),
          int'(o_trap[n]), e_trap[n]);
      chk(int'(o_cause[n]) == e_cause[n], e_tag[n], $sformatf("cause n=%0d", n),
          int'(o_cause[n]), e_cause[n]);
      chk(int'(o_cwp[n]) == m_cwp[n], e_tag[n], $sformatf("cwp n=%0d", n),
          int'(o_cwp[n]), m_cwp[n]);
      chk(int'(o_s[n]) == m_s[n], e_tag[n], $sformatf("sup n=%0d", n), int'(o_s[n]), m_s[n]);
      chk(int'(o_ps[n]) == m_ps[n], e_tag[n], $sformatf("prev_sup n=%0d", n),
          int'(o_ps[n]), m_ps[n]);
      chk(int'(o_et[n]) == m_et[n], e_tag[n], $sformatf("trap_en n=%0d", n),
          int'(o_et[n]), m_et[n]);
      chk(int'(o_pil[n]) == m_pil[n], e_tag[n], $sformatf("pil n=%0d", n),
          int'(o_pil[n]), m_pil[n]);
      chk(int'(o_stat[n]) == st, "R9", $sformatf("status word n=%0d", n),
          int'(o_stat[n]), st);
    end
  endtask

  // drive one beat at a falling edge, advance the model, check one cycle later
  task automatic apply(input bit valid, input logic [2:0] op, input logic [31:0] data);
    cmd_valid = valid;
    cmd_op    = op;
    cmd_data  = data;
    for (int n = NLO; n <= NHI; n++) begin
      int t;
      e_trap[n] = 0; e_cause[n] = 0; e_tag[n] = "R11";
      if (valid) begin
        case (op)
          3'd1: begin
            t = (m_cwp[n] + n - 1) % n;
            if (m_mask[t]) begin e_trap[n] = 1; e_cause[n] = 2; e_tag[n] = "R3"; end
            else begin m_cwp[n] = t; e_tag[n] = "R2"; end
          end
          3'd2: begin
            t = (m_cwp[n] + 1) % n;
            if (m_mask[t]) begin e_trap[n] = 1; e_cause[n] = 3; e_tag[n] = "R5"; end
            else begin m_cwp[n] = t; e_tag[n] = "R4"; end
          end
          3'd3: begin
            if (m_et[n] == 1) begin
              e_trap[n] = 1; e_cause[n] = 1; e_tag[n] = "R6";
            end else begin
              e_tag[n] = "R7";
              m_et[n] = 1;
              t = (m_cwp[n] + 1) % n;
              if (m_mask[t]) begin e_trap[n] = 1; e_cause[n] = 3; end
              else begin m_cwp[n] = t; m_s[n] = m_ps[n]; end
            end
          end
          3'd4: begin
            e_tag[n] = "R8";
            if (int'(data[4:0]) >= n) begin
              e_trap[n] = 1; e_cause[n] = 1;
            end else begin
              m_cwp[n] = int'(data[4:0]);
              m_s[n]   = int'(data[5]);
              m_ps[n]  = int'(data[6]);
              m_et[n]  = int'(data[7]);
              m_pil[n] = int'(data[11:8]);
            end
          end
          3'd5: e_tag[n] = "R10";
          default: e_tag[n] = "R11";
        endcase
      end
    end
    if (valid && op == 3'd5) m_mask = data;
    @(negedge clk);
    verify();
  endtask

  function automatic logic [31:0] step_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12: not ready while in reset
    for (int n = NLO; n <= NHI; n++)
      chk(o_rdy[n] == 1'b0, "R12", $sformatf("ready in reset n=%0d", n), int'(o_rdy[n]), 0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    verify();                                   // R1 reset state

    // R2 wrap from 0 down to NWIN-1, R4 wrap back up
    apply(1'b1, 3'd1, '0);
    apply(1'b1, 3'd2, '0);
    apply(1'b1, 3'd2, '0);
    // R3 / R5 with every window invalid
    apply(1'b1, 3'd5, 32'hffff_ffff);
    apply(1'b1, 3'd1, '0);
    apply(1'b1, 3'd2, '0);
    // R7 return with invalid target keeps pointer, sets enable; then R6
    apply(1'b1, 3'd3, '0);
    apply(1'b1, 3'd3, '0);
    // R10 bits above every ring size set only: no effect on moves
    apply(1'b1, 3'd5, 32'hffff_ff00);
    apply(1'b1, 3'd1, '0);
    apply(1'b1, 3'd1, '0);
    // R8 pointer field limits
    apply(1'b1, 3'd4, 32'h0000_005f);
    apply(1'b1, 3'd4, 32'h0000_0a47);
    apply(1'b1, 3'd4, 32'h0000_0341);
    apply(1'b1, 3'd3, '0);                      // R7 success: sup <- prev_sup
    // R11 idle and reserved codes
    apply(1'b0, 3'd1, '0);
    apply(1'b1, 3'd6, 32'hffff_ffff);
    apply(1'b1, 3'd7, '0);
    apply(1'b1, 3'd0, '0);

    for (int i = 0; i < RAND_STEPS; i++) begin
      logic [31:0] r, d;
      logic [2:0]  op;
      rng = step_rng(rng);
      r   = rng;
      op  = r[2:0];
      d   = r;
      if (op == 3'd4) d = {r[31:5], 5'(r[20:16] % 5'd10)};
      if (op == 3'd5) begin
        rng = step_rng(rng);
        d = r & rng;
      end
      apply(r[3] | r[4], op, d);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      miss_cnt++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
    end
  end

endmodule